// File: doc/BRIEF.md
# Single-Slope Column Counter Array

This block is the digital back end of a column-parallel single-slope converter. Each of its columns takes one comparator bit. A single sequencer steps every column through the same frame: a reset ramp, a signal ramp, and then a serial readout. All columns therefore start and stop counting on the same control signals. A column counts half clock periods while its comparator is still low. It counts downwards on the reset ramp and upwards on the signal ramp, so the value left at the end is the signal level minus the reset level. This is correlated double sampling, done in the digital domain.

Counting advances on both clock edges. A binary count on the rising edge carries the weight-two part. A falling-edge sample of the comparator settles the final odd half period. The resolution is chosen per frame, either 10 bits or 14 bits. Results are read through one multiplexer per group of eight columns. Each group drives a single serial line, words go out one after another, and each word is sent most significant bit first. The ramp generator, the comparators and the pixels are outside the block.

Top module: `ssc_column_array`

## Requirements
- R1: After reset `seq_state` is 0 (idle) and `ser_out`, `ser_valid` and `word_start` are 0. A `frame_start` seen on a clock edge while idle moves `seq_state` to 1 (reset ramp) for RST_CLKS clocks. It then moves to 2 (signal ramp) for 2^(B-1) clocks, where B is the selected resolution. It then moves to 3 (readout) for 8·B clocks, and then returns to 0.
- R2: `frame_start` has no effect while `seq_state` is not 0.
- R3: Within a ramp phase, a column counts one unit for every complete half clock period before its comparator is first seen high. The comparator is sampled on both clock edges. A comparator that stays low counts every half period of the phase.
- R4: The first high comparator level freezes the column's count for the rest of that phase, even if the comparator drops low again.
- R5: The column result is the signal-ramp count minus the reset-ramp count.
- R6: A negative difference gives result 0.
- R7: If the comparator never goes high during the signal ramp, the result is the full-scale code 2^B−1.
- R8: `hi_res`=1 selects B=14 and `hi_res`=0 selects B=10. The value is taken only on the accepted `frame_start` edge, and changes during a frame have no effect.
- R9: Results are right-aligned with the upper bits zero. In readout each word is B bits long and is sent most significant bit first.
- R10: Group g carries columns 8g to 8g+7 on `ser_out[g]` in ascending column order. `ser_valid` is high for the whole readout. `word_start` is high on the cycle of each word's first bit. Outside readout all serial outputs are 0.
- R11: The comparator inputs have no effect while idle or in readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counting uses both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a conversion frame when idle |
| hi_res | input | 1 | 1: 14-bit conversion, 0: 10-bit conversion |
| comp | input | N_COLS | Per-column comparator outputs, high once the ramp has crossed |
| seq_state | output | 2 | 0 idle, 1 reset ramp, 2 signal ramp, 3 readout |
| ser_out | output | N_COLS/8 | One serial data line per group of eight columns |
| ser_valid | output | 1 | Serial data is being shifted out |
| word_start | output | 1 | Current bit is the first bit of a column word |

## Verification
Directed frames place comparator crossings on even and odd half periods and at the first half of a ramp. They also cover the last half of the signal ramp and the case where the comparator never toggles. This separates off-by-one-edge errors in the two-edge counter from saturation and clamp faults. Columns whose reset count exceeds their signal count expose a missing clamp. Bouncing comparators (high then low again) show whether the count really freezes at the first crossing. Random frames in both resolutions, with comparator noise while idle, `hi_res` flipped mid-frame and `frame_start` pulsed during readout, check mode capture, word length and group ordering against values computed from the crossing times.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RST  = 2'd1,
      ST_SIG  = 2'd2,
      ST_RDO  = 2'd3
   } seq_e;
endpackage

// File: rtl/ssc_sequencer.sv
`timescale 1ns/1ps
module ssc_sequencer #(
   parameter int HI_BITS  = 14,
   parameter int LO_BITS  = 10,
   parameter int RST_CLKS = 32,
   parameter int WORDS    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic hi_res,
   output ssc_pkg::seq_e state,
   output logic mode_q,
   output logic frame_go,
   output logic ph_end,
   output logic [((WORDS > 1) ? $clog2(WORDS) : 1)-1:0] wsel,
   output logic [$clog2(HI_BITS+1)-1:0] bpos
);
   import ssc_pkg::*;

   localparam int CW  = HI_BITS;
   localparam int WSW = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int BPW = $clog2(HI_BITS+1);
   localparam logic [CW-1:0]  RST_LAST = CW'(RST_CLKS - 1);
   localparam logic [CW-1:0]  HI_LAST  = CW'((2**(HI_BITS-1)) - 1);
   localparam logic [CW-1:0]  LO_LAST  = CW'((2**(LO_BITS-1)) - 1);
   localparam logic [WSW-1:0] W_LAST   = WSW'(WORDS - 1);

   seq_e           state_q;
   logic [CW-1:0]  cnt_q;
   logic [WSW-1:0] wsel_q;
   logic [BPW-1:0] bsel_q;
   logic [BPW-1:0] bits_now;
   logic [CW-1:0]  sig_last;

   assign bits_now = mode_q ? BPW'(HI_BITS) : BPW'(LO_BITS);
   assign sig_last = mode_q ? HI_LAST : LO_LAST;
   assign frame_go = (state_q == ST_IDLE) && frame_start;
   assign ph_end   = ((state_q == ST_RST) && (cnt_q == RST_LAST)) ||
                     ((state_q == ST_SIG) && (cnt_q == sig_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         wsel_q  <= '0;
         bsel_q  <= '0;
         mode_q  <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (frame_start) begin
                  state_q <= ST_RST;
                  cnt_q   <= '0;
                  mode_q  <= hi_res;
               end
            end
            ST_RST: begin
               if (ph_end) begin
                  state_q <= ST_SIG;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_SIG: begin
               if (ph_end) begin
                  state_q <= ST_RDO;
                  wsel_q  <= '0;
                  bsel_q  <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (bsel_q == bits_now - 1'b1) begin
                  bsel_q <= '0;
                  if (wsel_q == W_LAST) begin
                     state_q <= ST_IDLE;
                  end else begin
                     wsel_q <= wsel_q + 1'b1;
                  end
               end else begin
                  bsel_q <= bsel_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign state = state_q;
   assign wsel  = wsel_q;
   assign bpos  = bits_now - 1'b1 - bsel_q;
endmodule

// File: rtl/ssc_column.sv
`timescale 1ns/1ps
module ssc_column #(
   parameter int HI_BITS = 14,
   parameter int LO_BITS = 10,
   parameter int AW      = HI_BITS + 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic comp,
   input  logic clear,
   input  logic count_en,
   input  logic count_up,
   input  logic ph_end,
   input  logic mode,
   output logic [HI_BITS-1:0] result
);
   localparam logic [AW-1:0] FS_HI = AW'((2**HI_BITS) - 1);
   localparam logic [AW-1:0] FS_LO = AW'((2**LO_BITS) - 1);

   logic                 cmp_mid;
   logic                 halted_q;
   logic signed [AW-1:0] acc_q;
   logic signed [AW-1:0] acc_nx;
   logic signed [AW-1:0] fs_s;
   logic [1:0]           step;
   logic [AW-1:0]        step_w;
   logic                 stop_now;
   logic                 latch;

   // falling-edge sample: decides whether the first half of a cycle counted
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) cmp_mid <= 1'b0;
      else        cmp_mid <= comp;
   end

   always_comb begin
      if (halted_q || cmp_mid) step = 2'd0;
      else if (comp)           step = 2'd1;
      else                     step = 2'd2;
   end

   assign step_w   = AW'(step);
   assign acc_nx   = count_up ? acc_q + $signed(step_w) : acc_q - $signed(step_w);
   assign stop_now = halted_q | cmp_mid | comp;
   assign fs_s     = mode ? $signed(FS_HI) : $signed(FS_LO);
   assign latch    = count_en && count_up && ph_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         halted_q <= 1'b0;
         result   <= '0;
      end else if (clear) begin
         acc_q    <= '0;
         halted_q <= 1'b0;
      end else if (count_en) begin
         acc_q    <= acc_nx;
         halted_q <= ph_end ? 1'b0 : stop_now;
         if (latch) begin
            if (!stop_now)         result <= fs_s[HI_BITS-1:0];
            else if (acc_nx < 0)    result <= '0;
            else if (acc_nx > fs_s) result <= fs_s[HI_BITS-1:0];
            else                    result <= acc_nx[HI_BITS-1:0];
         end
      end
   end
endmodule

// File: rtl/ssc_group_mux.sv
`timescale 1ns/1ps
module ssc_group_mux #(
   parameter int WORDS   = 8,
   parameter int HI_BITS = 14
) (
   input  logic [WORDS*HI_BITS-1:0] words,
   input  logic [((WORDS > 1) ? $clog2(WORDS) : 1)-1:0] wsel,
   input  logic [$clog2(HI_BITS+1)-1:0] bpos,
   input  logic en,
   output logic ser
);
   logic [HI_BITS-1:0] word_sel;

   always_comb begin
      word_sel = words[wsel*HI_BITS +: HI_BITS];
      ser      = en & word_sel[bpos];
   end
endmodule

// File: rtl/ssc_column_array.sv
`timescale 1ns/1ps
module ssc_column_array #(
   parameter int N_COLS     = 16,
   parameter int GROUP_SIZE = 8,
   parameter int HI_BITS    = 14,
   parameter int LO_BITS    = 10,
   parameter int RST_CLKS   = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         frame_start,
   input  logic                         hi_res,
   input  logic [N_COLS-1:0]            comp,
   output logic [1:0]                   seq_state,
   output logic [N_COLS/GROUP_SIZE-1:0] ser_out,
   output logic                         ser_valid,
   output logic                         word_start
);
   import ssc_pkg::*;

   localparam int N_GROUPS = N_COLS / GROUP_SIZE;
   localparam int AW       = HI_BITS + 2;
   localparam int WSW      = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1;
   localparam int BPW      = $clog2(HI_BITS+1);

   if (N_COLS % GROUP_SIZE != 0) begin : g_bad_group
      $error("N_COLS must be a multiple of GROUP_SIZE");
   end
   if (LO_BITS >= HI_BITS || LO_BITS < 2) begin : g_bad_res
      $error("LO_BITS must lie between 2 and HI_BITS-1");
   end
   if (RST_CLKS < 1 || 2*RST_CLKS >= 2**HI_BITS) begin : g_bad_rst
      $error("RST_CLKS out of range for the counter width");
   end

   seq_e                     state;
   logic                     mode_q;
   logic                     frame_go;
   logic                     ph_end;
   logic [WSW-1:0]           wsel;
   logic [BPW-1:0]           bpos;
   logic                     count_en;
   logic                     count_up;
   logic                     rdo_on;
   logic [N_COLS*HI_BITS-1:0] res_flat;

   ssc_sequencer #(
      .HI_BITS(HI_BITS), .LO_BITS(LO_BITS),
      .RST_CLKS(RST_CLKS), .WORDS(GROUP_SIZE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .hi_res(hi_res),
      .state(state), .mode_q(mode_q), .frame_go(frame_go), .ph_end(ph_end),
      .wsel(wsel), .bpos(bpos)
   );

   assign count_en = (state == ST_RST) || (state == ST_SIG);
   assign count_up = (state == ST_SIG);
   assign rdo_on   = (state == ST_RDO);

   for (genvar c = 0; c < N_COLS; c++) begin : g_col
      ssc_column #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS), .AW(AW)) u_col (
         .clk(clk), .rst_n(rst_n), .comp(comp[c]), .clear(frame_go),
         .count_en(count_en), .count_up(count_up), .ph_end(ph_end),
         .mode(mode_q), .result(res_flat[c*HI_BITS +: HI_BITS])
      );
   end

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      ssc_group_mux #(.WORDS(GROUP_SIZE), .HI_BITS(HI_BITS)) u_mux (
         .words(res_flat[g*GROUP_SIZE*HI_BITS +: GROUP_SIZE*HI_BITS]),
         .wsel(wsel), .bpos(bpos), .en(rdo_on), .ser(ser_out[g])
      );
   end

   assign seq_state  = state;
   assign ser_valid  = rdo_on;
   assign word_start = rdo_on && (bpos == BPW'(mode_q ? HI_BITS-1 : LO_BITS-1));
endmodule

// File: rtl/ssc_column_array_chk.sv
`timescale 1ns/1ps
module ssc_column_array_chk #(
   parameter int N_COLS   = 16,
   parameter int N_GROUPS = 2,
   parameter int HI_BITS  = 14,
   parameter int LO_BITS  = 10
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      frame_start,
   input logic [1:0]                seq_state,
   input logic [N_GROUPS-1:0]       ser_out,
   input logic                      ser_valid,
   input logic                      word_start,
   input logic                      mode_q,
   input logic [N_COLS*HI_BITS-1:0] res_flat
);
   logic upper_any;

   always_comb begin
      upper_any = 1'b0;
      for (int c = 0; c < N_COLS; c++) begin
         upper_any = upper_any | (|res_flat[c*HI_BITS+LO_BITS +: HI_BITS-LO_BITS]);
      end
   end

   p_idle_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd0) |=> (seq_state == 2'd0 || seq_state == 2'd1));
   p_rst_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd1) |=> (seq_state == 2'd1 || seq_state == 2'd2));
   p_sig_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd2) |=> (seq_state == 2'd2 || seq_state == 2'd3));
   p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd3 && frame_start) |=> (seq_state != 2'd1));
   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state != 2'd0) |=> $stable(mode_q));
   p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd3 && !mode_q) |-> !upper_any);
   p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd3) |=> (seq_state != 2'd3 || $stable(res_flat)));
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_valid |-> (ser_out == '0 && !word_start));
   p_first_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_valid) |-> word_start);
endmodule

bind ssc_column_array ssc_column_array_chk #(
   .N_COLS(N_COLS), .N_GROUPS(N_GROUPS), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .seq_state(seq_state),
   .ser_out(ser_out), .ser_valid(ser_valid), .word_start(word_start),
   .mode_q(mode_q), .res_flat(res_flat)
);

// File: tb/ssc_column_array_tb_top.sv
`timescale 1ns/1ps
module ssc_column_array_tb_top;
   localparam int NC = 16;
   localparam int GS = 8;
   localparam int NG = NC / GS;
   localparam int HI = 14;
   localparam int LO = 10;
   localparam int RC = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          hi_res = 1'b0;
   logic [NC-1:0] comp = '0;
   logic [1:0]    seq_state;
   logic [NG-1:0] ser_out;
   logic          ser_valid;
   logic          word_start;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int        t_rst  [NC];
   int        t_sig  [NC];
   bit        bounce [NC];
   logic [HI-1:0] exp_v [NC];

   always #10 clk = ~clk;

   ssc_column_array #(
      .N_COLS(NC), .GROUP_SIZE(GS), .HI_BITS(HI), .LO_BITS(LO), .RST_CLKS(RC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .hi_res(hi_res),
      .comp(comp), .seq_state(seq_state), .ser_out(ser_out),
      .ser_valid(ser_valid), .word_start(word_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   function automatic int exp_code(input int tr, input int ts, input bit hr);
      int kr;
      int ks;
      int dn;
      int d;
      kr = 2 * RC;
      ks = hr ? (2**HI) : (2**LO);
      dn = (tr >= kr) ? kr : tr;
      if (ts >= ks) return ks - 1;     // R7 saturation
      d = ts - dn;                     // R5 difference
      if (d < 0) return 0;             // R6 clamp
      if (d > ks - 1) return ks - 1;
      return d;
   endfunction

   // one ramp phase, driven half period by half period (R3, R4)
   task automatic drive_phase(input int halves, input bit sig);
      for (int h = 0; h < halves; h++) begin
         #1;
         if (h == 0) begin
            comp = '0;
            check(seq_state == (sig ? 2'd2 : 2'd1), "R1 phase state",
                  int'(seq_state), sig ? 2 : 1);
         end
         for (int c = 0; c < NC; c++) begin
            int t;
            t = sig ? t_sig[c] : t_rst[c];
            if (t == h) comp[c] = 1'b1;
            if (bounce[c] && h == t + 2) comp[c] = 1'b0;
         end
         if (h % 2 == 0) @(negedge clk);
         else            @(posedge clk);
      end
   endtask

   task automatic run_frame(input bit hr, input bit directed, input bit noisy);
      int kr;
      int ks;
      int bits;
      kr   = 2 * RC;
      ks   = hr ? (2**HI) : (2**LO);
      bits = hr ? HI : LO;
      for (int c = 0; c < NC; c++) begin
         t_rst[c]  = $urandom_range(kr, 0);
         t_sig[c]  = $urandom_range(ks, 0);
         bounce[c] = ($urandom_range(3, 0) == 0);
      end
      if (directed) begin
         t_rst[0] = 0;  t_sig[0] = 0;      bounce[0] = 0; // R5 zero
         t_rst[1] = kr; t_sig[1] = ks;     bounce[1] = 0; // R7 never
         t_rst[2] = 10; t_sig[2] = 5;      bounce[2] = 0; // R6 clamp
         t_rst[3] = 7;  t_sig[3] = 300;    bounce[3] = 0; // R3 odd halves
         t_rst[4] = kr; t_sig[4] = ks - 1; bounce[4] = 0; // R3 last half
         t_rst[5] = 0;  t_sig[5] = ks - 1; bounce[5] = 0; // full scale
         t_rst[6] = 20; t_sig[6] = 21;     bounce[6] = 1; // R4 bounce
         t_rst[7] = 5;  t_sig[7] = 100;    bounce[7] = 1; // R4 bounce
         t_rst[8] = 63; t_sig[8] = 64;     bounce[8] = 0;
         t_rst[9] = kr; t_sig[9] = 0;      bounce[9] = 0; // R6
      end
      for (int c = 0; c < NC; c++) exp_v[c] = HI'(exp_code(t_rst[c], t_sig[c], hr));

      if (noisy) begin
         // R11: comparator activity while idle must not leak into the frame
         @(negedge clk);
         comp = NC'($urandom());
         repeat (3) @(negedge clk);
         comp = NC'($urandom());
      end
      @(negedge clk);
      frame_start = 1'b1;
      hi_res      = hr;
      @(posedge clk);
      #1;
      frame_start = 1'b0;
      hi_res      = ~hr;                  // R8: ignored until next frame
      drive_phase(kr, 1'b0);
      drive_phase(ks, 1'b1);
      #1;
      if (noisy) frame_start = 1'b1;     // R2: ignored during readout
      for (int w = 0; w < GS; w++) begin
         for (int b = 0; b < bits; b++) begin
            @(negedge clk);
            if (w == 1 && b == 0) frame_start = 1'b0;
            check(ser_valid == 1'b1, "R10 ser_valid", int'(ser_valid), 1);
            check(word_start == (b == 0), "R10 word_start", int'(word_start), int'(b == 0));
            for (int g = 0; g < NG; g++) begin
               check(ser_out[g] == exp_v[g*GS+w][bits-1-b], "R5 R9 serial bit",
                     int'(ser_out[g]), int'(exp_v[g*GS+w][bits-1-b]));
            end
         end
      end
      @(negedge clk);
      check(seq_state == 2'd0, "R1 back to idle", int'(seq_state), 0);
      check(ser_valid == 1'b0 && ser_out == '0, "R10 quiet after readout",
            int'(ser_out), 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(seq_state == 2'd0, "R1 reset state", int'(seq_state), 0);
      check(ser_out == '0 && !ser_valid && !word_start, "R1 reset outputs",
            int'({ser_out, ser_valid, word_start}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(seq_state == 2'd0, "R1 idle without frame_start", int'(seq_state), 0);
      run_frame(1'b0, 1'b1, 1'b0);
      run_frame(1'b1, 1'b1, 1'b1);
      for (int f = 0; f < 6; f++) run_frame(1'b0, 1'b0, 1'b1);
      run_frame(1'b1, 1'b0, 1'b1);
      run_frame(1'b0, 1'b1, 1'b1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule